// File: doc/BRIEF.md
# Host Register Bank with Outbound Packet Mailbox

This block is the byte-wide register bank that a host reaches through the serial target interface of a wireless power receiver. The target answers at 7-bit address 0x6C. A separate front end decodes the serial frames and presents each access to this block as a simple register cycle: an address, write data, and a one-cycle write strobe or read strobe. This block does not handle the serial bit-level protocol.

The bank holds four groups of state:
- two configuration registers that stay writable at all times: the output feedback target and the current-limit percentage;
- control bits: alignment aid and unscaled current limit;
- two read-back status values: the power mode and the power-signal frequency code;
- a mailbox that hands one proprietary packet (a header byte and four payload bytes) to the packet engine.

All addresses from 0xE0 upward sit in a region that depends on the rectifier being above lockout. While the `uvlo` input is high, that region is held at its reset contents and host writes to it are dropped.

The mailbox uses a write-zero-to-send scheme. The host writes 0 into the done bit of 0xE0. If the header in 0xE2 is legal, the bank raises a request to the packet engine. The bank sets the done bit back to 1 when the engine reports completion, and it records a 2-bit result code.

Top module: `hreg_host_regs`

## Requirements
- R1: After synchronous reset the bank reads 0x01 at address 0x01, 0x07 at 0x02 and 0x80 at 0xE0. Every other writable register reads 0x00. `fb_sel` is 1, `ilim_sel` is 7 and `pkt_req` is 0.
- R2: Bits 2:0 of address 0x01 drive `fb_sel`, which selects a feedback target of 450 mV + 50 mV × code. Bits 7:3 of this register are not stored and read as 0.
- R3: Bits 2:0 of address 0x02 drive `ilim_sel`. The codes 0 to 7 mean 10, 20, 30, 40, 50, 60, 80 and 100 % of the current limit. Bits 7:3 read as 0.
- R4: Addresses 0x01 and 0x02 accept writes while `uvlo` is high, and they keep their values through a lockout episode.
- R5: While `uvlo` is high, addresses 0xE0 to 0xFF behave as follows:
  - reads return the reset contents (0x80 at 0xE0, 0x00 elsewhere, including the status addresses);
  - writes are dropped;
  - one cycle after `uvlo` rises, `pkt_req`, `align_en`, `ilim_unscaled`, the header and the payload are all cleared.
- R6: The following fields are writable by the host, and all other bits at these addresses read 0:
  - bit 3 of 0xE0 drives `align_en`;
  - bit 1 of 0xF0 drives `ilim_unscaled`;
  - 0xE2 holds the header and drives `pkt_hdr`;
  - 0xF1 to 0xF4 hold the payload and drive `pkt_payload` (0xF1 in bits 7:0, up to 0xF4 in bits 31:24).
- R7: Bit 7 of 0xEF mirrors `pwr_mode_hi` (1 means 10 W mode), and 0xFB mirrors `freq_code`. Host writes to either address change nothing.
- R8: The host starts a send by writing 0xE0 with bit 7 at 0 while the mailbox is idle and the header is legal. The legal headers are 0x18, 0x28, 0x38 and 0x48. The cycle after the write, `pkt_req` is 1, bit 7 of 0xE0 reads 0, and bits 6:5 read 00.
- R9: If the header is not legal when a send is started, no request is raised. Bit 7 of 0xE0 stays 1 and bits 6:5 read 10.
- R10: While `pkt_req` is high, a cycle with `pkt_done` high has three effects, visible from the next cycle:
  - `pkt_req` drops;
  - bit 7 of 0xE0 returns to 1;
  - bits 6:5 read 01 if `pkt_no_tx` was high in that cycle, and 00 otherwise.
- R11: While a request is pending:
  - writes to 0xE2 and to 0xF1 to 0xF4 are dropped;
  - writing 1 to bit 7 of 0xE0 neither cancels the request nor starts a second one.
- R12: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value until the next read. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo | input | 1 | High while the rectifier is below lockout |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| pwr_mode_hi | input | 1 | Power mode status, 1 = 10 W |
| freq_code | input | 8 | Power-signal frequency code |
| fb_sel | output | 3 | Output feedback target code |
| ilim_sel | output | 3 | Current-limit percentage code |
| ilim_unscaled | output | 1 | Disable 2x current-limit scaling between modes |
| align_en | output | 1 | Alignment-aid mode enable |
| pkt_req | output | 1 | Packet send request to the engine |
| pkt_hdr | output | 8 | Packet header |
| pkt_payload | output | 32 | Packet payload, first byte in bits 7:0 |
| pkt_done | input | 1 | Engine completion pulse |
| pkt_no_tx | input | 1 | With `pkt_done`: no transmitter was present |

## Verification
If the mailbox state is wrong, the error shows within one cycle of the triggering event. A request that is raised but never retired leaves `pkt_req` high and 0xE0 reading with bit 7 clear. A wrong result code shows up in bits 6:5 on the next read.

If the lockout clear does not happen, stale header, payload or control bits appear at the first read or port sample after `uvlo` falls. If a busy interlock is missing, the header or payload changes while the request is still pending.

The bench therefore reads back every address after each mailbox transition and after each lockout episode. It also samples the mailbox ports one cycle after each strobe.

// File: rtl/hreg_pkg.sv
// Package: shared constants and helper functions for the host register bank.
// Assumes an 8-bit address and an 8-bit data register bus.
package hreg_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int PAY_N     = 4;
    localparam int N_LEGAL   = 4;

    // Register addresses.
    localparam logic [7:0] A_FBSEL   = 8'h01;
    localparam logic [7:0] A_ILSEL   = 8'h02;
    localparam logic [7:0] A_LOCKLO  = 8'hE0;
    localparam logic [7:0] A_MBX     = 8'hE0;
    localparam logic [7:0] A_HDR     = 8'hE2;
    localparam logic [7:0] A_MODE    = 8'hEF;
    localparam logic [7:0] A_CTRL    = 8'hF0;
    localparam logic [7:0] A_PAY0    = 8'hF1;
    localparam logic [7:0] A_FREQ    = 8'hFB;

    // Mailbox result codes.
    localparam logic [1:0] MB_OK      = 2'b00;
    localparam logic [1:0] MB_NO_TX   = 2'b01;
    localparam logic [1:0] MB_BAD_HDR = 2'b10;

    localparam logic [7:0] LEGAL_HDR [N_LEGAL] = '{8'h18, 8'h28, 8'h38, 8'h48};

    // Returns 1 when the header byte is one of the legal values.
    function automatic logic hdr_legal(input logic [7:0] h);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < N_LEGAL; i++) begin
            if (h == LEGAL_HDR[i]) ok = 1'b1;
        end
        return ok;
    endfunction

    // Returns 1 for every address that decodes to a register.
    function automatic logic addr_mapped(input logic [7:0] a);
        logic m;
        m = (a == A_FBSEL) || (a == A_ILSEL) || (a == A_MBX) || (a == A_HDR) ||
            (a == A_MODE) || (a == A_CTRL) || (a == A_FREQ);
        for (int i = 0; i < PAY_N; i++) begin
            if (a == A_PAY0 + 8'(i)) m = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/hreg_cfg_field.sv
// Module: hreg_cfg_field
// A configuration field of W bits at one address that is always writable.
// It does not depend on the lockout state.
// Assumes: the write strobe is one cycle wide; only bits W-1:0 of the data are stored.
module hreg_cfg_field #(
    parameter int             W    = 3,
    parameter logic [W-1:0]   RSTV = '0,
    parameter logic [7:0]     ADDR = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [7:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] field
);
    logic [W-1:0] q;

    // Holds the field; it loads on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= RSTV;
        else if (wr && addr == ADDR) q <= wdata;
    end

    assign field = q;

    AST_CFG_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (field == RSTV)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && addr == ADDR)) |=> $stable(field)); // R4
endmodule

// File: rtl/hreg_lock_bank.sv
// Module: hreg_lock_bank
// Holds the data registers of the lockout region: the two control bits,
// the packet header and the payload bytes.
// Assumes: uvlo clears the bank synchronously; busy (a pending request)
// freezes the header and the payload.
module hreg_lock_bank
    import hreg_pkg::*;
#(
    parameter int N_PAY = PAY_N
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  uvlo,
    input  logic                  busy,
    input  logic                  wr,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic                  align_en,
    output logic                  ilim_unscaled,
    output logic [7:0]            hdr,
    output logic [N_PAY*8-1:0]    payload
);
    logic clr;
    assign clr = !rst_n || uvlo;

    // Alignment-aid and unscaled-limit control bits.
    always_ff @(posedge clk) begin
        if (clr) begin
            align_en      <= 1'b0;
            ilim_unscaled <= 1'b0;
        end else if (wr) begin
            if (addr == A_MBX)  align_en      <= wdata[3];
            if (addr == A_CTRL) ilim_unscaled <= wdata[1];
        end
    end

    // Header byte; it is frozen while a request is pending.
    always_ff @(posedge clk) begin
        if (clr)                                hdr <= '0;
        else if (wr && !busy && addr == A_HDR)  hdr <= wdata;
    end

    // One register per payload byte, each frozen while a request is pending.
    for (genvar g = 0; g < N_PAY; g++) begin : g_pay
        always_ff @(posedge clk) begin
            if (clr)                                          payload[g*8 +: 8] <= '0;
            else if (wr && !busy && addr == A_PAY0 + 8'(g))   payload[g*8 +: 8] <= wdata;
        end
    end

    AST_HDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !uvlo) |=> $stable(hdr)); // R11
    AST_PAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !uvlo) |=> $stable(payload)); // R11
    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (hdr == 8'h00 && payload == '0 && !align_en && !ilim_unscaled)); // R5
endmodule

// File: rtl/hreg_mailbox.sv
// Module: hreg_mailbox
// Write-zero-to-send handshake. It checks the header, raises the request,
// retires the request on a completion pulse and keeps the 2-bit result code.
// Assumes: the header input is frozen by the data bank while the request is up.
module hreg_mailbox
    import hreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic       wdata_msb,
    input  logic [7:0] hdr,
    input  logic       pkt_done,
    input  logic       pkt_no_tx,
    output logic       pkt_req,
    output logic       done_bit,
    output logic [1:0] err
);
    logic start_wr;
    assign start_wr = wr && (addr == A_MBX) && !wdata_msb;

    // Request and result-code state.
    always_ff @(posedge clk) begin
        if (!rst_n || uvlo) begin
            pkt_req <= 1'b0;
            err     <= MB_OK;
        end else if (pkt_req) begin
            if (pkt_done) begin
                pkt_req <= 1'b0;
                err     <= pkt_no_tx ? MB_NO_TX : MB_OK;
            end
        end else if (start_wr) begin
            if (hdr_legal(hdr)) begin
                pkt_req <= 1'b1;
                err     <= MB_OK;
            end else begin
                err     <= MB_BAD_HDR;
            end
        end
    end

    assign done_bit = !pkt_req;

    AST_REQ_LEGAL_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> hdr_legal(hdr)); // R8
    AST_REQ_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_done) |=> !pkt_req); // R10
    AST_UVLO_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!pkt_req && err == MB_OK)); // R5
    AST_BAD_HDR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_req && start_wr && !uvlo && !hdr_legal(hdr)) |=> (!pkt_req && err == MB_BAD_HDR)); // R9
endmodule

// File: rtl/hreg_host_regs.sv
// Module: hreg_host_regs (top)
// The host register bank. It contains two always-writable configuration fields,
// a lockout region (control bits, mailbox, header and payload), read-only status
// mirrors and a registered read multiplexer.
// Assumes: bus_wr and bus_rd are one-cycle strobes from a serial target front end.
module hreg_host_regs
    import hreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uvlo,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic        pwr_mode_hi,
    input  logic [7:0]  freq_code,
    output logic [2:0]  fb_sel,
    output logic [2:0]  ilim_sel,
    output logic        ilim_unscaled,
    output logic        align_en,
    output logic        pkt_req,
    output logic [7:0]  pkt_hdr,
    output logic [31:0] pkt_payload,
    input  logic        pkt_done,
    input  logic        pkt_no_tx
);
    localparam logic [SEL_W-1:0] FB_RST = SEL_W'(1);
    localparam logic [SEL_W-1:0] IL_RST = SEL_W'(7);

    logic       lock_wr;
    logic       done_bit;
    logic [1:0] mb_err;
    logic [7:0] rd_mux;
    logic [7:0] rdata_q;
    logic       in_lock;

    assign in_lock = (bus_addr >= A_LOCKLO);
    assign lock_wr = bus_wr && !uvlo && in_lock;

    hreg_cfg_field #(.W(SEL_W), .RSTV(FB_RST), .ADDR(A_FBSEL)) u_fb (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[SEL_W-1:0]), .field(fb_sel));

    hreg_cfg_field #(.W(SEL_W), .RSTV(IL_RST), .ADDR(A_ILSEL)) u_il (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[SEL_W-1:0]), .field(ilim_sel));

    hreg_lock_bank #(.N_PAY(PAY_N)) u_bank (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .busy(pkt_req),
        .wr(lock_wr), .addr(bus_addr), .wdata(bus_wdata),
        .align_en(align_en), .ilim_unscaled(ilim_unscaled),
        .hdr(pkt_hdr), .payload(pkt_payload));

    hreg_mailbox u_mbx (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr(lock_wr), .addr(bus_addr),
        .wdata_msb(bus_wdata[7]), .hdr(pkt_hdr), .pkt_done(pkt_done),
        .pkt_no_tx(pkt_no_tx), .pkt_req(pkt_req), .done_bit(done_bit), .err(mb_err));

    // Read multiplexer; during lockout the region reads as its reset contents.
    always_comb begin
        rd_mux = 8'h00;
        if (uvlo && in_lock) begin
            rd_mux = (bus_addr == A_MBX) ? 8'h80 : 8'h00;
        end else begin
            case (bus_addr)
                A_FBSEL: rd_mux = {5'b0, fb_sel};
                A_ILSEL: rd_mux = {5'b0, ilim_sel};
                A_MBX:   rd_mux = {done_bit, mb_err, 1'b0, align_en, 3'b000};
                A_HDR:   rd_mux = pkt_hdr;
                A_MODE:  rd_mux = {pwr_mode_hi, 7'b0};
                A_CTRL:  rd_mux = {6'b0, ilim_unscaled, 1'b0};
                A_FREQ:  rd_mux = freq_code;
                default: rd_mux = 8'h00;
            endcase
            for (int i = 0; i < PAY_N; i++) begin
                if (bus_addr == A_PAY0 + 8'(i)) rd_mux = pkt_payload[i*8 +: 8];
            end
        end
    end

    // Read data register; it loads on the read strobe and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !addr_mapped(bus_addr)) |=> (bus_rdata == 8'h00)); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12
    AST_LOCK_FREQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && uvlo && bus_addr == A_FREQ) |=> (bus_rdata == 8'h00)); // R5
endmodule

// File: tb/hreg_host_regs_tb_top.sv
// Scoreboard bench: the read task pushes expected bytes, and a monitor pops
// them and compares each one with bus_rdata one cycle later.
module hreg_host_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uvlo = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        pwr_mode_hi = 1'b0;
    logic [7:0]  freq_code = '0;
    logic [2:0]  fb_sel;
    logic [2:0]  ilim_sel;
    logic        ilim_unscaled;
    logic        align_en;
    logic        pkt_req;
    logic [7:0]  pkt_hdr;
    logic [31:0] pkt_payload;
    logic        pkt_done = 1'b0;
    logic        pkt_no_tx = 1'b0;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    hreg_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pwr_mode_hi(pwr_mode_hi), .freq_code(freq_code),
        .fb_sel(fb_sel), .ilim_sel(ilim_sel), .ilim_unscaled(ilim_unscaled),
        .align_en(align_en), .pkt_req(pkt_req), .pkt_hdr(pkt_hdr),
        .pkt_payload(pkt_payload), .pkt_done(pkt_done), .pkt_no_tx(pkt_no_tx));

    // Monitor: compares the read data one cycle after each read strobe.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic done_pulse(input logic no_tx);
        @(negedge clk); pkt_done = 1'b1; pkt_no_tx = no_tx;
        @(negedge clk); pkt_done = 1'b0; pkt_no_tx = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1ms;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(fb_sel, 1, "R1 fb_sel");
        chk(ilim_sel, 7, "R1 ilim_sel");
        chk(pkt_req, 0, "R1 pkt_req");
        rd_reg(8'h01, 8'h01, "R1 0x01");
        rd_reg(8'h02, 8'h07, "R1 0x02");
        rd_reg(8'hE0, 8'h80, "R1 0xE0");
        rd_reg(8'hE2, 8'h00, "R1 0xE2");
        // R2 / R3 config fields
        wr_reg(8'h01, 8'hFD);
        chk(fb_sel, 5, "R2 fb_sel");
        rd_reg(8'h01, 8'h05, "R2 upper bits zero");
        wr_reg(8'h02, 8'h12);
        chk(ilim_sel, 2, "R3 ilim_sel");
        rd_reg(8'h02, 8'h02, "R3 readback");
        // R6 writable lockout fields
        wr_reg(8'hE0, 8'h88);
        chk(align_en, 1, "R6 align_en");
        rd_reg(8'hE0, 8'h88, "R6 0xE0");
        wr_reg(8'hF0, 8'hFF);
        chk(ilim_unscaled, 1, "R6 ilim_unscaled");
        rd_reg(8'hF0, 8'h02, "R6 0xF0");
        wr_reg(8'hE2, 8'h28);
        wr_reg(8'hF1, 8'h11); wr_reg(8'hF2, 8'h22);
        wr_reg(8'hF3, 8'h33); wr_reg(8'hF4, 8'h44);
        chk(pkt_hdr, 8'h28, "R6 pkt_hdr");
        chk(pkt_payload, 32'h44332211, "R6 pkt_payload");
        rd_reg(8'hF3, 8'h33, "R6 0xF3");
        // R7 read-only mirrors
        pwr_mode_hi = 1'b1; freq_code = 8'h9C;
        rd_reg(8'hEF, 8'h80, "R7 mode");
        rd_reg(8'hFB, 8'h9C, "R7 freq");
        wr_reg(8'hEF, 8'h7F); wr_reg(8'hFB, 8'h00);
        rd_reg(8'hEF, 8'h80, "R7 mode after write");
        rd_reg(8'hFB, 8'h9C, "R7 freq after write");
        // R12 unmapped
        wr_reg(8'h03, 8'hAA);
        rd_reg(8'h03, 8'h00, "R12 unmapped 0x03");
        rd_reg(8'hE5, 8'h00, "R12 unmapped 0xE5");
        // R8 send
        wr_reg(8'hE0, 8'h08);
        chk(pkt_req, 1, "R8 pkt_req");
        rd_reg(8'hE0, 8'h08, "R8 done cleared");
        // R11 busy interlock
        wr_reg(8'hE2, 8'h55); wr_reg(8'hF1, 8'h99);
        wr_reg(8'hE0, 8'h88);
        chk(pkt_req, 1, "R11 not cancelled");
        rd_reg(8'hE2, 8'h28, "R11 hdr frozen");
        rd_reg(8'hF1, 8'h11, "R11 payload frozen");
        // R10 completion with no transmitter
        done_pulse(1'b1);
        chk(pkt_req, 0, "R10 req dropped");
        rd_reg(8'hE0, 8'hA8, "R10 no-tx code");
        wr_reg(8'hE0, 8'h08);
        chk(pkt_req, 1, "R8 second send");
        done_pulse(1'b0);
        rd_reg(8'hE0, 8'h88, "R10 ok code");
        // R9 illegal header
        wr_reg(8'hE2, 8'h77);
        wr_reg(8'hE0, 8'h08);
        chk(pkt_req, 0, "R9 no request");
        rd_reg(8'hE0, 8'hC8, "R9 bad header code");
        // R5 / R4 lockout with a pending request
        wr_reg(8'hE2, 8'h18);
        wr_reg(8'hE0, 8'h00);
        chk(pkt_req, 1, "R8 legal 0x18");
        @(negedge clk); uvlo = 1'b1;
        @(negedge clk);
        chk(pkt_req, 0, "R5 req cleared");
        chk(align_en, 0, "R5 align cleared");
        chk(ilim_unscaled, 0, "R5 unscaled cleared");
        rd_reg(8'hE0, 8'h80, "R5 0xE0 in lockout");
        rd_reg(8'hFB, 8'h00, "R5 freq in lockout");
        rd_reg(8'hEF, 8'h00, "R5 mode in lockout");
        wr_reg(8'hE2, 8'h48);
        wr_reg(8'h01, 8'h03);
        rd_reg(8'h01, 8'h03, "R4 write in lockout");
        @(negedge clk); uvlo = 1'b0;
        rd_reg(8'hE2, 8'h00, "R5 hdr write dropped");
        rd_reg(8'hF1, 8'h00, "R5 payload cleared");
        rd_reg(8'hE0, 8'h80, "R5 mailbox reset");
        rd_reg(8'h01, 8'h03, "R4 kept through lockout");
        rd_reg(8'h02, 8'h02, "R4 0x02 kept");
        rd_reg(8'hFB, 8'h9C, "R7 freq after lockout");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R12 all reads answered");
        finish_run();
    end
endmodule